// File: doc/BRIEF.md
# Streaming 7x7 Weighted Smoothing Filter

This block smooths a raster video stream of 8-bit grey pixels, one pixel per clock. Each pixel is weighted with its 7x7 neighbourhood by a programmable kernel. The block keeps the six most recent complete image lines, plus the line being received, in seven line memories. These memories are written in round-robin order. A rotating selector presents the stored lines oldest-first to a 7x7 register window. The window shifts by one column for every accepted pixel and feeds 49 parallel multipliers and a fully registered adder tree.

Upstream logic supplies pixels with a valid strobe and a frame-start marker. A host loads the 49 kernel weights through a simple write port. Only interior pixels are produced: results for the three outermost rows and columns on each side are dropped. Results leave with their own valid, first-of-frame and last-of-line markers. The image width is a parameter, with a default of 1024.

Top module: `conv7x7_stream`

## Requirements
- R1: After reset, and until the seventh line of a frame has started arriving, `outValid` stays low. A frame of six or fewer lines gives no output.
- R2: A frame of H full lines of IMG_W pixels gives exactly (H-6)*(IMG_W-6) outputs. They come in raster order, for centre rows 3..H-4 and centre columns 3..IMG_W-4.
- R3: The output for centre (y,x) is S = sum over r,c in 0..6 of w[r*7+c]*p[y-3+r][x-3+c], then (S+128)>>8. Weight index r selects the image row (r=0 is the top) and c selects the column (c=0 is the left).
- R4: A rounded result above 255 is output as 255.
- R5: A write with `coefWe` high stores `coefData` into weight `coefAddr` for addresses 0..48. Addresses 49..63 change nothing. Weights persist across frames.
- R6: Frames taller than seven lines are filtered correctly, although each line memory is reused every seven lines.
- R7: `outEol` is high only with the output for centre column IMG_W-4. `outSof` is high only with the output for centre (3,3). Both appear only together with `outValid`.
- R8: A pixel with `inSof` high is taken as row 0, column 0 of a new frame, whatever came before it. Lines from an abandoned frame never form part of an output window.
- R9: With the default kernel size, each output appears exactly 9 clock edges after the edge that accepted pixel (y+3, x+3).
- R10: Idle cycles (`inValid` low) between pixels do not change any output value or marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Pixel accepted on this edge |
| inSof | input | 1 | Accepted pixel is the first of a frame |
| inPix | input | 8 | Input pixel value |
| coefWe | input | 1 | Weight write strobe |
| coefAddr | input | 6 | Weight index, r*7+c |
| coefData | input | 8 | Unsigned weight value |
| outValid | output | 1 | Filtered pixel present |
| outSof | output | 1 | First filtered pixel of the frame |
| outEol | output | 1 | Last filtered pixel of its row |
| outPix | output | 8 | Filtered pixel value |

## Verification
The properties assume that every frame opens with a pixel marked `inSof`. They also assume that every line carries exactly IMG_W accepted pixels and that reset is held long enough to empty the pipeline. The bench drives only whole lines and raises the frame marker on the first pixel of each frame. For the restart cases it abandons a frame only by starting a new one with `inSof`. Weights are changed only between frames, so each frame is checked against one fixed kernel.

// File: rtl/conv7_pkg.sv
`timescale 1ns/1ps
package conv7_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // pixel accepted: write line memory, read stored column
    logic shift;  // stored column ready: shift window by one column
  } ctl_t;

  // markers travelling alongside the arithmetic pipeline
  typedef struct packed {
    logic valid;
    logic sof;
    logic eol;
  } mark_t;

endpackage

// File: rtl/conv7_ctrl.sv
`timescale 1ns/1ps
module conv7_ctrl
  import conv7_pkg::*;
#(
  parameter int IMG_W = 1024,
  parameter int KSZ   = 7,
  parameter int LAT   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  input  logic                      inSof,
  output logic [$clog2(IMG_W)-1:0]  curCol,
  output logic [$clog2(KSZ)-1:0]    curSlot,
  output logic [$clog2(KSZ)-1:0]    winSlot,
  output ctl_t                      ctl,
  output mark_t                     outMark
);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int SLOT_W = $clog2(KSZ);
  localparam int ROW_W  = $clog2(KSZ + 1);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(IMG_W - 1);
  localparam logic [COL_W-1:0]  FULL_COL  = COL_W'(KSZ - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(KSZ - 1);
  localparam logic [ROW_W-1:0]  FULL_ROW  = ROW_W'(KSZ - 1);
  localparam logic [ROW_W-1:0]  ROW_MAX   = ROW_W'(KSZ);

  logic [COL_W-1:0]  colCnt, col1;
  logic [SLOT_W-1:0] slotCnt;
  logic [ROW_W-1:0]  rowCnt, curRow;
  logic              v1, ready1, first1;
  mark_t             winMark;
  mark_t             dly [LAT];

  // a frame-start pixel always lands at row 0, column 0, slot 0
  assign curCol  = inSof ? '0 : colCnt;
  assign curSlot = inSof ? '0 : slotCnt;
  assign curRow  = inSof ? '0 : rowCnt;

  assign ctl.wrEn  = inValid;
  assign ctl.shift = v1;
  assign outMark   = dly[LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt  <= '0;
      slotCnt <= '0;
      rowCnt  <= '0;
    end else if (inValid) begin
      if (curCol == LAST_COL) begin
        colCnt  <= '0;
        slotCnt <= (curSlot == LAST_SLOT) ? '0 : curSlot + 1'b1;
        rowCnt  <= (curRow == ROW_MAX) ? curRow : curRow + 1'b1;
      end else begin
        colCnt  <= curCol + 1'b1;
        slotCnt <= curSlot;
        rowCnt  <= curRow;
      end
    end
  end

  // stage 1: stored column is being read out of the line memories
  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      col1    <= '0;
      winSlot <= '0;
      ready1  <= 1'b0;
      first1  <= 1'b0;
    end else begin
      v1 <= inValid;
      if (inValid) begin
        col1    <= curCol;
        winSlot <= curSlot;
        ready1  <= (curRow >= FULL_ROW);
        first1  <= (curRow == FULL_ROW);
      end
    end
  end

  // stage 2: window holds a complete neighbourhood
  always_ff @(posedge clk) begin
    if (rst) begin
      winMark <= '0;
    end else begin
      winMark.valid <= v1 && ready1 && (col1 >= FULL_COL);
      winMark.sof   <= v1 && first1 && (col1 == FULL_COL);
      winMark.eol   <= v1 && ready1 && (col1 == LAST_COL);
    end
  end

  // markers follow the multiply-add pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) dly[i] <= '0;
    end else begin
      dly[0] <= winMark;
      for (int i = 1; i < LAT; i++) dly[i] <= dly[i-1];
    end
  end

endmodule

// File: rtl/conv7_datapath.sv
`timescale 1ns/1ps
module conv7_datapath
  import conv7_pkg::*;
#(
  parameter int IMG_W      = 1024,
  parameter int KSZ        = 7,
  parameter int PIX_W      = 8,
  parameter int COEF_W     = 8,
  parameter int NORM_SHIFT = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  ctl_t                              ctl,
  input  logic [$clog2(IMG_W)-1:0]          wrCol,
  input  logic [$clog2(KSZ)-1:0]            wrSlot,
  input  logic [$clog2(KSZ)-1:0]            winSlot,
  input  logic [PIX_W-1:0]                  inPix,
  input  logic                              coefWe,
  input  logic [$clog2(KSZ*KSZ)-1:0]        coefAddr,
  input  logic [COEF_W-1:0]                 coefData,
  output logic [PIX_W-1:0]                  outPix
);
  localparam int NTAP   = KSZ * KSZ;
  localparam int ADDR_W = $clog2(NTAP);
  localparam int SLOT_W = $clog2(KSZ);
  localparam int LEVELS = $clog2(NTAP);
  localparam int SUM_W  = PIX_W + COEF_W + LEVELS;
  localparam int PAD    = NTAP + 1;
  localparam int Q_W    = SUM_W - NORM_SHIFT + 1;

  logic [COEF_W-1:0]      coef [NTAP];
  logic [KSZ*PIX_W-1:0]   rdBus;
  logic [PIX_W-1:0]       pix1;
  logic [PIX_W-1:0]       newCol [KSZ];
  logic [PIX_W-1:0]       win [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) coef[i] <= '0;
    end else if (coefWe && (coefAddr < ADDR_W'(NTAP))) begin
      coef[coefAddr] <= coefData;
    end
  end

  // line memories: read the stored column, overwrite the slot of the current row
  for (genvar s = 0; s < KSZ; s++) begin : g_line
    logic [PIX_W-1:0] mem [IMG_W];
    logic [PIX_W-1:0] rdq;
    always_ff @(posedge clk) begin
      if (ctl.wrEn) begin
        rdq <= mem[wrCol];
        if (wrSlot == SLOT_W'(s)) mem[wrCol] <= inPix;
      end
    end
    assign rdBus[s*PIX_W +: PIX_W] = rdq;
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) pix1 <= inPix;
  end

  // rotating selector: slot after the current one holds the oldest row
  always_comb begin
    int j;
    for (int k = 0; k < KSZ - 1; k++) begin
      j = int'(winSlot) + 1 + k;
      if (j >= KSZ) j = j - KSZ;
      newCol[k] = rdBus[j*PIX_W +: PIX_W];
    end
    newCol[KSZ-1] = pix1;
  end

  always_ff @(posedge clk) begin
    if (ctl.shift) begin
      for (int r = 0; r < KSZ; r++) begin
        for (int c = 0; c < KSZ - 1; c++) win[r*KSZ+c] <= win[r*KSZ+c+1];
        win[r*KSZ+KSZ-1] <= newCol[r];
      end
    end
  end

  // level 0 multiplies, levels 1..LEVELS add pairs; entries past the live count stay zero
  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int CNT = (NTAP + (1 << l) - 1) >> l;
    logic [SUM_W-1:0] sum [PAD];
    if (l == 0) begin : g_mul
      always_ff @(posedge clk) begin
        sum <= '{default: '0};
        for (int i = 0; i < NTAP; i++) sum[i] <= SUM_W'(coef[i]) * SUM_W'(win[i]);
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        sum <= '{default: '0};
        for (int i = 0; i < CNT; i++) sum[i] <= lvl[l-1].sum[2*i] + lvl[l-1].sum[2*i+1];
      end
    end
  end

  logic [SUM_W:0] rounded;
  logic [Q_W-1:0] quot;
  assign rounded = {1'b0, lvl[LEVELS].sum[0]} + (SUM_W+1)'(1 << (NORM_SHIFT - 1));
  assign quot    = rounded[SUM_W:NORM_SHIFT];

  always_ff @(posedge clk) begin
    if (rst)                    outPix <= '0;
    else if (|quot[Q_W-1:PIX_W]) outPix <= '1;
    else                        outPix <= quot[PIX_W-1:0];
  end

endmodule

// File: rtl/conv7x7_stream.sv
`timescale 1ns/1ps
module conv7x7_stream
  import conv7_pkg::*;
#(
  parameter int IMG_W      = 1024,
  parameter int KSZ        = 7,
  parameter int PIX_W      = 8,
  parameter int COEF_W     = 8,
  parameter int NORM_SHIFT = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic                        inSof,
  input  logic [PIX_W-1:0]            inPix,
  input  logic                        coefWe,
  input  logic [$clog2(KSZ*KSZ)-1:0]  coefAddr,
  input  logic [COEF_W-1:0]           coefData,
  output logic                        outValid,
  output logic                        outSof,
  output logic                        outEol,
  output logic [PIX_W-1:0]            outPix
);
  localparam int LEVELS = $clog2(KSZ * KSZ);
  localparam int LAT    = LEVELS + 2;

  ctl_t                     ctl;
  mark_t                    mark;
  logic [$clog2(IMG_W)-1:0] curCol;
  logic [$clog2(KSZ)-1:0]   curSlot, winSlot;

  conv7_ctrl #(.IMG_W(IMG_W), .KSZ(KSZ), .LAT(LAT)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
    .curCol(curCol), .curSlot(curSlot), .winSlot(winSlot),
    .ctl(ctl), .outMark(mark)
  );

  conv7_datapath #(
    .IMG_W(IMG_W), .KSZ(KSZ), .PIX_W(PIX_W), .COEF_W(COEF_W), .NORM_SHIFT(NORM_SHIFT)
  ) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .wrCol(curCol), .wrSlot(curSlot),
    .winSlot(winSlot), .inPix(inPix), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .outPix(outPix)
  );

  assign outValid = mark.valid;
  assign outSof   = mark.sof;
  assign outEol   = mark.eol;

endmodule

// File: rtl/conv7x7_stream_chk.sv
`timescale 1ns/1ps
module conv7x7_stream_chk #(
  parameter int KSZ = 7
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic outValid,
  input logic outSof,
  input logic outEol
);
  localparam int DEPTH = $clog2(KSZ * KSZ) + 4;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);

  // R9
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, DEPTH));

  // R7
  eol_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outEol |-> outValid);

  // R7
  sof_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outSof |-> outValid);

  // R7
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    outSof |=> !outSof);

endmodule

bind conv7x7_stream conv7x7_stream_chk #(.KSZ(KSZ)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid),
  .outValid(outValid), .outSof(outSof), .outEol(outEol)
);

// File: tb/conv7x7_stream_tb_top.sv
`timescale 1ns/1ps
module conv7x7_stream_tb_top;
  localparam int W  = 12;
  localparam int NT = 49;
  localparam int HMAX = 16;
  // kmode, tap, imode, seed, height, gap
  localparam int TBL [7][6] = '{
    '{0,  0, 0, 77, 10, 0},
    '{0,  0, 1,  5, 12, 0},
    '{1,  0, 1,  9, 12, 1},
    '{1, 48, 1, 21, 11, 0},
    '{1,  6, 1, 33,  9, 2},
    '{2,  0, 2,  0,  8, 0},
    '{1, 42, 1, 44,  7, 0}
  };

  logic clk = 0, rst = 1, inValid = 0, inSof = 0, coefWe = 0;
  logic [7:0] inPix = 0, coefData = 0;
  logic [5:0] coefAddr = 0;
  logic outValid, outSof, outEol;
  logic [7:0] outPix;

  int checks = 0, fails = 0, cyc = 0;
  int kc [64];
  int img [HMAX][W];
  int inCyc [HMAX][W];
  int capPix [256], capCyc [256];
  bit capEol [256], capSof [256];
  int capN = 0;
  bit capOn = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv7x7_stream #(.IMG_W(W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outSof(outSof), .outEol(outEol), .outPix(outPix)
  );

  always @(negedge clk) begin
    if (capOn && outValid) begin
      if (capN < 256) begin
        capPix[capN] = outPix; capCyc[capN] = cyc;
        capEol[capN] = outEol; capSof[capN] = outSof;
      end
      capN++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrCoef(int a, int d);
    @(negedge clk); coefWe = 1; coefAddr = 6'(a); coefData = 8'(d);
    @(negedge clk); coefWe = 0;
    if (a < NT) kc[a] = d;   // R5 model: high addresses are ignored
  endtask

  task automatic setKernel(int kmode, int tap);
    int wv [7] = '{1, 2, 3, 4, 3, 2, 1};
    for (int i = 0; i < NT; i++) begin
      if (kmode == 0)      wrCoef(i, wv[i/7] * wv[i%7]);
      else if (kmode == 1) wrCoef(i, (i == tap) ? 255 : 0);
      else                 wrCoef(i, 255);
    end
  endtask

  function automatic int pixVal(int imode, int seed, int y, int x);
    if (imode == 0) return seed;
    if (imode == 1) return ((x*37 + y*101 + seed*53) ^ (x*y*7)) & 255;
    return 255;
  endfunction

  task automatic sendFrame(int h, int imode, int seed, int gap, int stopAt);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < W; x++) begin
        if (y*W + x < stopAt) begin
          img[y][x] = pixVal(imode, seed, y, x);
          @(negedge clk);
          inValid = 1; inSof = (y == 0 && x == 0); inPix = 8'(img[y][x]);
          inCyc[y][x] = cyc + 1;
          for (int g = 0; g < gap; g++) begin
            @(negedge clk); inValid = 0; inSof = 0;
          end
        end
      end
    end
    @(negedge clk); inValid = 0; inSof = 0;
  endtask

  task automatic runFrame(int h, int imode, int seed, int gap, string vtag);
    int idx;
    capN = 0; capOn = 1;
    sendFrame(h, imode, seed, gap, h*W);
    repeat (20) @(negedge clk);
    capOn = 0;
    check(capN == (h-6)*(W-6), "R2", "output count", capN, (h-6)*(W-6));
    idx = 0;
    for (int y = 3; y <= h-4; y++) begin
      for (int x = 3; x <= W-4; x++) begin
        if (idx < capN && idx < 256) begin
          int s, e;
          s = 0;
          for (int r = 0; r < 7; r++)
            for (int c = 0; c < 7; c++) s += kc[r*7+c] * img[y-3+r][x-3+c];
          e = (s + 128) >> 8;
          if (e > 255) e = 255;
          check(capPix[idx] == e, vtag, "pixel value", capPix[idx], e);
          check(capEol[idx] == (x == W-4), "R7", "row-end marker", capEol[idx], x == W-4);
          check(capSof[idx] == (idx == 0), "R7", "frame-start marker", capSof[idx], idx == 0);
          check(capCyc[idx] == inCyc[y+3][x+3] + 9, "R9", "output edge",
                capCyc[idx], inCyc[y+3][x+3] + 9);
        end
        idx++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) kc[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid == 0, "R1", "valid after reset", outValid, 0);
    end

    // table walk: kernel, image pattern, height and idle gaps vary per row
    for (int t = 0; t < 7; t++) begin
      string tag;
      tag = (TBL[t][5] > 0) ? "R10" : (TBL[t][0] == 2) ? "R4" : (TBL[t][4] > 7) ? "R6" : "R3";
      setKernel(TBL[t][0], TBL[t][1]);
      runFrame(TBL[t][4], TBL[t][2], TBL[t][3], TBL[t][5], tag);
    end

    // R5: writes to addresses 49..63 leave the kernel untouched
    setKernel(0, 0);
    for (int a = 49; a < 64; a++) wrCoef(a, 255);
    runFrame(12, 1, 61, 0, "R5");

    // R1: six lines only, nothing comes out
    capN = 0; capOn = 1;
    sendFrame(6, 1, 3, 0, 6*W);
    repeat (20) @(negedge clk);
    capOn = 0;
    check(capN == 0, "R1", "outputs from six-line frame", capN, 0);

    // R8: abandon a frame mid-line, restart with frame marker
    capN = 0; capOn = 1;
    sendFrame(9, 2, 0, 0, 4*W + 5);
    capOn = 0;
    check(capN == 0, "R8", "outputs from abandoned frame", capN, 0);
    setKernel(1, 0);
    runFrame(10, 1, 77, 0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule